// File: doc/BRIEF.md
# Dithered Colour Scaling Unit

This block conditions one colour byte at a time before it is sent to a serial pixel line. Each byte carries a channel index (three channels by default). The unit first adds that channel's temporal dither offset to the byte, saturating at 0xFF, and leaves a zero byte at zero. It then multiplies the result by the channel's 8-bit brightness factor. The multiplier is a bit-serial shift-and-add that keeps only the upper byte of the product.

Once a byte has taken its dither, the channel's dither value advances to the channel modifier minus the old dither. Successive frames therefore land on different rounding points. Bytes enter and leave through valid/ready handshakes. Per-channel factors, dither values and modifiers are loaded through a small write port. A parameter can remove the dither path, so that bytes are only scaled.

Top module: `pix_scaler`

## Requirements
- R1: With dither enabled, a nonzero input byte v on channel c becomes min(v + d_c, 255) before scaling, and a zero input byte stays zero.
- R2: The output byte equals (dithered byte × scale_c) >> 8, truncated, so a dithered byte of 0xFF with a scale of 0xFF gives 0xFE.
- R3: A write with `cfg_we` high sets one field of channel `cfg_ch`, chosen by `cfg_sel`: 0 selects the scale, 1 the dither value and 2 the modifier. A `cfg_sel` of 3, or a `cfg_ch` of NUM_CH or above, changes nothing.
- R4: After each byte on channel c, d_c becomes (m_c − d_c) mod 256, where m_c is that channel's modifier. The other channels keep their dither values.
- R5: With DITHER_EN = 0 the output is (v × scale_c) >> 8, with no offset added.
- R6: `in_ready` is high only while the unit is idle. It is low from the accepting edge until the edge that completes the output handshake, and `in_ready` and `out_valid` are never high together.
- R7: `out_valid` rises on the 9th rising edge after the edge that accepts a byte: 1 edge for the dither stage and 8 for the multiply.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays constant.
- R9: A configuration write while `in_ready` is low has no effect.
- R10: A configuration write in the same cycle as a byte is accepted takes effect, and that byte already uses the written value.
- R11: After reset `in_ready` is 1, `out_valid` is 0, and all scales, dither values and modifiers are 0, so any byte yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 2 | Field select: 0 scale, 1 dither, 2 modifier, 3 none |
| cfg_data | input | 8 | Value written |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Unit idle and able to take a byte |
| in_data | input | 8 | Raw colour byte |
| in_ch | input | CH_W | Channel of the input byte, below NUM_CH |
| out_valid | output | 1 | Scaled byte present |
| out_ready | input | 1 | Consumer takes the scaled byte |
| out_data | output | 8 | Scaled byte |

## Verification
A configuration write and a byte acceptance can fall in the same cycle. In that case the write must win and must already shape the byte being accepted. The bench provokes this by raising `cfg_we` (to a scale or to a dither value) on the same edge as `in_valid`. It judges the result by comparing `out_data` against a product computed from the newly written value. The complementary case drives a write while a byte is in flight and expects the old value to persist. Both the value seen by later bytes and a checker property on the stored scales and modifiers enforce this.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
  localparam int PXW = 8;

  typedef enum logic [1:0] {
    SEL_SCALE = 2'd0,
    SEL_DITH  = 2'd1,
    SEL_MOD   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DITH = 2'd1,
    ST_MUL  = 2'd2,
    ST_OUT  = 2'd3
  } st_e;

  // offset add: zero is kept, overflow clamps at all ones
  function automatic logic [PXW-1:0] sat_offset(input logic [PXW-1:0] v,
                                                input logic [PXW-1:0] d);
    logic [PXW:0] s;
    s = {1'b0, v} + {1'b0, d};
    if (v == '0) return '0;
    return s[PXW] ? {PXW{1'b1}} : s[PXW-1:0];
  endfunction

  // one multiply step: conditional add, then drop the low bit into the carry path
  function automatic logic [PXW-1:0] mul_step(input logic [PXW-1:0] acc,
                                              input logic [PXW-1:0] m,
                                              input logic b);
    logic [PXW:0] s;
    s = {1'b0, acc} + (b ? {1'b0, m} : {(PXW+1){1'b0}});
    return s[PXW:1];
  endfunction

  function automatic logic [PXW-1:0] dither_next(input logic [PXW-1:0] m,
                                                 input logic [PXW-1:0] d);
    return m - d;
  endfunction
endpackage

// File: rtl/pxs_chan_regs.sv
module pxs_chan_regs
  import pxs_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [CH_W-1:0]       wr_ch,
  input  cfg_sel_e              wr_sel,
  input  logic [PXW-1:0]        wr_data,
  input  logic                  upd_en,
  input  logic [CH_W-1:0]       sel_ch,
  output logic [PXW-1:0]        rd_scale,
  output logic [PXW-1:0]        rd_dith,
  output logic [NUM_CH*PXW-1:0] scale_flat,
  output logic [NUM_CH*PXW-1:0] mod_flat
);
  logic [PXW-1:0] sc_q [NUM_CH];
  logic [PXW-1:0] dq_q [NUM_CH];
  logic [PXW-1:0] mq_q [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        sc_q[c] <= '0;
        dq_q[c] <= '0;
        mq_q[c] <= '0;
      end
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en && wr_ch == CH_W'(c)) begin
          case (wr_sel)
            SEL_SCALE: sc_q[c] <= wr_data;
            SEL_DITH:  dq_q[c] <= wr_data;
            SEL_MOD:   mq_q[c] <= wr_data;
            default:   ;
          endcase
        end else if (upd_en && sel_ch == CH_W'(c)) begin
          dq_q[c] <= dither_next(mq_q[c], dq_q[c]);
        end
      end
    end
  end

  always_comb begin
    rd_scale = '0;
    rd_dith  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_ch == CH_W'(c)) begin
        rd_scale = sc_q[c];
        rd_dith  = dq_q[c];
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign scale_flat[c*PXW +: PXW] = sc_q[c];
    assign mod_flat[c*PXW +: PXW]   = mq_q[c];
  end
endmodule

// File: rtl/pxs_dither.sv
module pxs_dither
  import pxs_pkg::*;
#(
  parameter bit EN = 1'b1
) (
  input  logic [PXW-1:0] raw,
  input  logic [PXW-1:0] offs,
  output logic [PXW-1:0] dithered
);
  if (EN) begin : g_on
    assign dithered = sat_offset(raw, offs);
  end else begin : g_off
    logic unused_offs;
    assign unused_offs = ^offs;
    assign dithered    = raw;
  end
endmodule

// File: rtl/pxs_serial_mul.sv
module pxs_serial_mul
  import pxs_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [PXW-1:0] opnd,
  input  logic [PXW-1:0] scl,
  output logic           last,
  output logic [PXW-1:0] prod
);
  localparam int CW = $clog2(PXW);

  logic [PXW-1:0] acc_q, m_q, s_q;
  logic [CW-1:0]  cnt_q;
  logic           run_q;

  assign last = run_q && (cnt_q == CW'(PXW-1));
  assign prod = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      m_q   <= '0;
      s_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      acc_q <= '0;
      m_q   <= opnd;
      s_q   <= scl;
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      acc_q <= mul_step(acc_q, m_q, s_q[cnt_q]);
      cnt_q <= cnt_q + 1'b1;
      if (last) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pix_scaler.sv
module pix_scaler
  import pxs_pkg::*;
#(
  parameter int  NUM_CH    = 3,
  parameter bit  DITHER_EN = 1'b1,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CH_W-1:0]  cfg_ch,
  input  logic [1:0]       cfg_sel,
  input  logic [PXW-1:0]   cfg_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PXW-1:0]   in_data,
  input  logic [CH_W-1:0]  in_ch,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PXW-1:0]   out_data
);
  st_e             st_q;
  logic [PXW-1:0]  byte_q;
  logic [CH_W-1:0] ch_q;

  // named events for the checker
  logic acc_fire, dith_fire, cfg_ok, mul_last;
  logic [PXW-1:0] rd_scale, rd_dith, dith_out, prod;
  logic [NUM_CH*PXW-1:0] scale_flat, mod_flat;

  assign in_ready  = (st_q == ST_IDLE);
  assign out_valid = (st_q == ST_OUT);
  assign acc_fire  = in_valid && in_ready;
  assign dith_fire = (st_q == ST_DITH);
  assign cfg_ok    = cfg_we && (st_q == ST_IDLE);
  assign out_data  = prod;

  pxs_chan_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_ok),
    .wr_ch     (cfg_ch),
    .wr_sel    (cfg_sel_e'(cfg_sel)),
    .wr_data   (cfg_data),
    .upd_en    (dith_fire && DITHER_EN),
    .sel_ch    (ch_q),
    .rd_scale  (rd_scale),
    .rd_dith   (rd_dith),
    .scale_flat(scale_flat),
    .mod_flat  (mod_flat)
  );

  pxs_dither #(.EN(DITHER_EN)) dith_i (
    .raw     (byte_q),
    .offs    (rd_dith),
    .dithered(dith_out)
  );

  pxs_serial_mul mul_i (
    .clk  (clk),
    .rst_n(rst_n),
    .start(dith_fire),
    .opnd (dith_out),
    .scl  (rd_scale),
    .last (mul_last),
    .prod (prod)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      byte_q <= '0;
      ch_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (acc_fire) begin
          byte_q <= in_data;
          ch_q   <= in_ch;
          st_q   <= ST_DITH;
        end
        ST_DITH: st_q <= ST_MUL;
        ST_MUL:  if (mul_last) st_q <= ST_OUT;
        ST_OUT:  if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pxs_checker.sv
module pxs_checker
  import pxs_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [PXW-1:0]        out_data,
  input logic                  cfg_we,
  input logic                  acc_fire,
  input logic                  dith_fire,
  input logic [PXW-1:0]        dith_in,
  input logic [PXW-1:0]        dith_out,
  input logic [NUM_CH*PXW-1:0] scale_flat,
  input logic [NUM_CH*PXW-1:0] mod_flat
);
  localparam int LAT = PXW + 1;

  logic [4:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                       lat_q <= '0;
    else if (acc_fire)                lat_q <= '0;
    else if (!in_ready && !out_valid) lat_q <= lat_q + 1'b1;
  end

  p_ready_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == 5'(LAT)));

  p_zero_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dith_fire && dith_in == '0) |-> (dith_out == '0));

  p_no_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dith_fire |-> (dith_out >= dith_in));

  p_busy_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !in_ready) |=> ($stable(scale_flat) && $stable(mod_flat)));
endmodule

bind pix_scaler pxs_checker #(.NUM_CH(NUM_CH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .cfg_we    (cfg_we),
  .acc_fire  (acc_fire),
  .dith_fire (dith_fire),
  .dith_in   (byte_q),
  .dith_out  (dith_out),
  .scale_flat(scale_flat),
  .mod_flat  (mod_flat)
);

// File: tb/pix_scaler_tb_top.sv
module pix_scaler_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_data = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] in_ch = '0;
  logic       out_ready = 1'b0;
  logic       in_ready, out_valid, in_ready_nd, out_valid_nd;
  logic [7:0] out_data, out_data_nd;

  int checks = 0;
  int fails = 0;
  int bs[3], bd[3], be[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_scaler #(.NUM_CH(3), .DITHER_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_ch(in_ch), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  pix_scaler #(.NUM_CH(3), .DITHER_EN(1'b0)) dut_nd (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready_nd), .in_data(in_data),
    .in_ch(in_ch), .out_valid(out_valid_nd), .out_ready(out_ready), .out_data(out_data_nd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_write(input int ch, input int sel, input int val);
    if (ch < 3) begin
      if (sel == 0) bs[ch] = val;
      else if (sel == 1) bd[ch] = val;
      else if (sel == 2) be[ch] = val;
    end
  endtask

  task automatic cfg_wr(input int ch, input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_data = 8'(val);
    model_write(ch, sel, val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // mode 0: plain, 1: write on the accepting edge, 2: write while busy
  task automatic send(input int v, input int ch, input int hold,
                      input int mode, input int wsel, input int wval);
    int lat, dv, exp, expn;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'(v); in_ch = 2'(ch);
    if (mode == 1) begin
      cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(wsel); cfg_data = 8'(wval);
      model_write(ch, wsel, wval);
    end
    @(negedge clk);
    in_valid = 1'b0; cfg_we = 1'b0;
    lat = 0;
    chk(in_ready == 1'b0, "R6 busy after accept", int'(in_ready), 0);
    if (mode == 2) begin
      cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(wsel); cfg_data = 8'(wval);
      @(negedge clk);
      cfg_we = 1'b0;
      lat++;
    end
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 9, "R7 latency", lat, 9);
    dv   = (v == 0) ? 0 : ((v + bd[ch] > 255) ? 255 : v + bd[ch]);
    exp  = (dv * bs[ch]) >> 8;
    expn = (v * bs[ch]) >> 8;
    bd[ch] = (be[ch] - bd[ch]) & 255;
    chk(int'(out_data) == exp, "R1 R2 R4 scaled data", int'(out_data), exp);
    chk(int'(out_data_nd) == expn, "R5 undithered data", int'(out_data_nd), expn);
    chk(in_ready == 1'b0, "R6 ready low with output", int'(in_ready), 0);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      chk(out_valid && int'(out_data) == exp, "R8 held output", int'(out_data), exp);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, "R6 idle after handshake", int'(in_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin bs[i] = 0; bd[i] = 0; be[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R11 reset ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
    // R11: cleared scale gives zero on every channel
    for (int c = 0; c < 3; c++) send(255, c, 0, 0, 0, 0);

    cfg_wr(0, 0, 8'hFF); cfg_wr(0, 1, 8'h10); cfg_wr(0, 2, 8'h33);
    cfg_wr(1, 0, 8'h80); cfg_wr(1, 1, 8'hF0); cfg_wr(1, 2, 8'h05);
    cfg_wr(2, 0, 8'h5A); cfg_wr(2, 1, 8'h01); cfg_wr(2, 2, 8'hFF);
    // sweep every byte value over rotating channels (R1 R2 R4 R5)
    for (int v = 0; v < 256; v++) send(v, v % 3, 0, 0, 0, 0);

    // R2 corner: 0xFF times 0xFF gives 0xFE
    cfg_wr(0, 1, 0);
    send(255, 0, 0, 0, 0, 0);
    // R1 saturation and zero
    cfg_wr(1, 1, 8'hF0); cfg_wr(1, 0, 8'hFF);
    send(8'h20, 1, 0, 0, 0, 0);
    send(0, 1, 0, 0, 0, 0);

    // R3: select 3 and out-of-range channel change nothing
    cfg_wr(0, 3, 8'h77);
    cfg_wr(3, 0, 8'h00);
    for (int c = 0; c < 3; c++) send(8'h9C, c, 0, 0, 0, 0);

    // R8: consumer stalls
    send(8'hC3, 2, 5, 0, 0, 0);
    send(8'h01, 0, 2, 0, 0, 0);

    // R9: writes while busy are dropped (model untouched)
    send(8'h40, 2, 0, 2, 0, 8'h00);
    send(8'h40, 2, 0, 2, 1, 8'hAA);
    send(8'h40, 2, 0, 0, 0, 0);
    // R10: write on the accepting edge applies to that byte
    send(8'h40, 2, 0, 1, 0, 8'h11);
    send(8'h80, 1, 0, 1, 1, 8'hFE);
    send(8'h80, 1, 0, 0, 0, 0);

    // second sweep with extreme scales and short stalls (R2 R4 R5 R8)
    cfg_wr(0, 0, 8'h01); cfg_wr(1, 0, 8'hFF); cfg_wr(2, 0, 8'h00);
    cfg_wr(1, 2, 8'h7F);
    for (int v = 255; v >= 0; v -= 3) send(v, v % 3, v % 2, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule